// File: doc/BRIEF.md
# GPIO Bank with Pin Resolution and Event Interrupts

This block is a 32-pin general-purpose I/O bank that sits behind a 32-bit register port. For every pin it resolves a level from the following sources:

- the output latch;
- the output enable;
- the push-pull or open-drain output type;
- the weak pull resistors;
- a polarity inversion;
- an input enable.

It then reports the sampled value back as the data-in word. The polarity bit acts on both paths. It inverts the value driven onto the pin, and it inverts the value read back from the pin.

Each pin also feeds an event detector. The detector can flag a high level, a rising edge, or either edge, and it records the result in a sticky status bit that software clears by writing a 1. Status bits that are also enabled are ORed together into one interrupt line.

The output latch, the output enable and the event enable each have a set alias and a clear alias, so software can change single bits without a read-modify-write. A soft lock freezes the output latch and its aliases until a two-word key sequence opens it again.

The register port is a plain control interface with no back-pressure:

- A write is taken on every rising clock edge where `cfg_we` is high.
- Reads are combinational from `cfg_raddr`.

Pin levels and the interrupt are plain level outputs.

Top module: `gpio_bank`

## Requirements
- R1: After reset, pull-up (0x1C) and input enable (0x58) read all ones. Polarity (0x08), data-out (0x0C), output enable (0x10), output type (0x14), pull-down (0x20), event type (0x28), both-edge (0x2C) and event enable (0x40) read zero. Lock (0x00) reads 0, data-in (0x04) reads all ones, and `irq` is low.
- R2: The driven value of a pin is data-out XOR polarity. When output enable is 1 and output type is 0, the pin takes the driven value. Data-in (0x04) is (pin AND input-enable) XOR polarity.
- R3: When output enable is 1 and output type is 1 (open drain), a driven 0 pulls the pin low and a driven 1 leaves it at its pull value. When output enable is 0, the pin takes its pull value. The pull value is 1 exactly when the pull-up bit is 1 and the pull-down bit is 0.
- R4: A data-in bit whose input-enable bit is 0 reads as its polarity bit.
- R5: Writing to set aliases ORs the written ones into a register, and writing to clear aliases removes them:
  - data-out: set 0x68, clear 0x6C;
  - output enable: set 0x70, clear 0x74;
  - event enable: set 0x44, clear 0x48.

  Aliases read as zero.
- R6: Any write to 0x00 or 0x7C locks the bank, and 0x00 then reads 1. While the bank is locked, writes to data-out and its two aliases are ignored, and every other register stays writable.
- R7: Writing 0xC0DE1248 to 0x7C arms the unlock, and the bank then unlocks if the very next write is 0xC0DEFA73 to 0x00. Any other intervening write, or a wrong value, leaves the bank locked.
- R8: With event-type bit 0 (level), the status bit is set on each clock edge where its data-in bit is 1. It stays set after the input falls.
- R9: With event-type bit 1 and both-edge bit 0, only a 0-to-1 change of data-in sets status.
- R10: With event-type bit 1 and both-edge bit 1, both rising and falling changes of data-in set status.
- R11: Event status (0x4C) is write-1-to-clear, and bits written as 0 are kept. If an event and a clear hit the same bit on the same edge, the event wins.
- R12: `irq` is high exactly when (status AND event enable) is nonzero. It follows an enable change on the same edge that writes the enable.
- R13: Edge detection compares data-in with its value on the previous edge. A write that changes data-in sets status on the following edge, and produces one event per changed bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 7 | Byte offset of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 7 | Byte offset of the combinational read |
| cfg_rdata | output | 32 | Read data |
| pin_o | output | 32 | Resolved pin levels |
| irq | output | 1 | Interrupt: enabled pending events |

## Verification
A wrong output-latch, enable or pull state shows at once on `pin_o` and on the data-in read, in the same cycle as the write that caused it. A corrupted lock or arming flag shows only when the next data-out write is either ignored or accepted against the rules, so the lock sequences are probed with a write and read-back right after each step. Event state errors appear one edge after the stimulating write, as a status word or an `irq` level that differs from the expected value. Checks are therefore placed both right after the write, where status must not have changed yet, and one edge later.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W = 32;
  localparam int OFS_W = 7;

  // Register offsets (byte addresses decoded by software)
  localparam logic [OFS_W-1:0] OFS_LOCK_PRI  = 7'h00;
  localparam logic [OFS_W-1:0] OFS_DATA_IN   = 7'h04;
  localparam logic [OFS_W-1:0] OFS_POLARITY  = 7'h08;
  localparam logic [OFS_W-1:0] OFS_DOUT      = 7'h0C;
  localparam logic [OFS_W-1:0] OFS_OUT_EN    = 7'h10;
  localparam logic [OFS_W-1:0] OFS_OUT_TYPE  = 7'h14;
  localparam logic [OFS_W-1:0] OFS_PULL_UP   = 7'h1C;
  localparam logic [OFS_W-1:0] OFS_PULL_DN   = 7'h20;
  localparam logic [OFS_W-1:0] OFS_EV_TYPE   = 7'h28;
  localparam logic [OFS_W-1:0] OFS_EV_BOTH   = 7'h2C;
  localparam logic [OFS_W-1:0] OFS_EV_EN     = 7'h40;
  localparam logic [OFS_W-1:0] OFS_EV_EN_SET = 7'h44;
  localparam logic [OFS_W-1:0] OFS_EV_EN_CLR = 7'h48;
  localparam logic [OFS_W-1:0] OFS_EV_STAT   = 7'h4C;
  localparam logic [OFS_W-1:0] OFS_IN_EN     = 7'h58;
  localparam logic [OFS_W-1:0] OFS_DOUT_SET  = 7'h68;
  localparam logic [OFS_W-1:0] OFS_DOUT_CLR  = 7'h6C;
  localparam logic [OFS_W-1:0] OFS_OE_SET    = 7'h70;
  localparam logic [OFS_W-1:0] OFS_OE_CLR    = 7'h74;
  localparam logic [OFS_W-1:0] OFS_LOCK_SEC  = 7'h7C;

  // Unlock keys: first to the secondary lock, then to the primary one
  localparam logic [BUS_W-1:0] KEY_ARM  = 32'hC0DE1248;
  localparam logic [BUS_W-1:0] KEY_OPEN = 32'hC0DEFA73;
endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] dout,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] oe,
  input  logic [NPIN-1:0] otyp,
  input  logic [NPIN-1:0] pu,
  input  logic [NPIN-1:0] pd,
  input  logic [NPIN-1:0] ie,
  output logic [NPIN-1:0] pin,
  output logic [NPIN-1:0] din
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic drive_val;
    logic pull_val;
    always_comb begin
      drive_val = dout[i] ^ pol[i];
      pull_val  = pu[i] & ~pd[i];
      if (!oe[i])             pin[i] = pull_val;
      else if (!otyp[i])      pin[i] = drive_val;   // push-pull
      else if (!drive_val)    pin[i] = 1'b0;        // open drain sinks
      else                    pin[i] = pull_val;    // open drain released
      din[i] = (pin[i] & ie[i]) ^ pol[i];
    end
  end
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic             locked,
  output logic             armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      armed  <= 1'b0;
    end else if (we) begin
      case (addr)
        OFS_LOCK_SEC: begin
          locked <= 1'b1;
          armed  <= (wdata == KEY_ARM);
        end
        OFS_LOCK_PRI: begin
          locked <= !(armed && (wdata == KEY_OPEN));
          armed  <= 1'b0;
        end
        default: armed <= 1'b0;   // sequence must be back to back
      endcase
    end
  end
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] din,
  input  logic [NPIN-1:0] mode_edge,
  input  logic [NPIN-1:0] mode_both,
  input  logic [NPIN-1:0] ack,
  input  logic [NPIN-1:0] en,
  output logic [NPIN-1:0] status,
  output logic            irq
);
  logic [NPIN-1:0] din_q;
  logic [NPIN-1:0] hit;

  for (genvar i = 0; i < NPIN; i++) begin : g_det
    logic rise;
    logic fall;
    always_comb begin
      rise = din[i] & ~din_q[i];
      fall = ~din[i] & din_q[i];
      if (!mode_edge[i])     hit[i] = din[i];
      else if (mode_both[i]) hit[i] = rise | fall;
      else                   hit[i] = rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      din_q  <= '1;   // matches data-in right after reset: no false edge
    end else begin
      status <= (status & ~ack) | hit;
      din_q  <= din;
    end
  end

  assign irq = |(status & en);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFS_W-1:0] cfg_waddr,
  input  logic [BUS_W-1:0] cfg_wdata,
  input  logic [OFS_W-1:0] cfg_raddr,
  output logic [BUS_W-1:0] cfg_rdata,
  output logic [NPIN-1:0]  pin_o,
  output logic             irq
);
  logic [NPIN-1:0] pol_q, dout_q, oe_q, otyp_q, pu_q, pd_q, ie_q;
  logic [NPIN-1:0] evtyp_q, evboth_q, even_q;
  logic [NPIN-1:0] din, ev_status, ack_bits, wbits;
  logic            locked, unlock_armed;

  assign wbits    = cfg_wdata[NPIN-1:0];
  assign ack_bits = (cfg_we && cfg_waddr == OFS_EV_STAT) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= '0;
      dout_q   <= '0;
      oe_q     <= '0;
      otyp_q   <= '0;
      pu_q     <= '1;
      pd_q     <= '0;
      ie_q     <= '1;
      evtyp_q  <= '0;
      evboth_q <= '0;
      even_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_waddr)
        OFS_POLARITY:  pol_q    <= wbits;
        OFS_DOUT:      if (!locked) dout_q <= wbits;
        OFS_DOUT_SET:  if (!locked) dout_q <= dout_q | wbits;
        OFS_DOUT_CLR:  if (!locked) dout_q <= dout_q & ~wbits;
        OFS_OUT_EN:    oe_q     <= wbits;
        OFS_OE_SET:    oe_q     <= oe_q | wbits;
        OFS_OE_CLR:    oe_q     <= oe_q & ~wbits;
        OFS_OUT_TYPE:  otyp_q   <= wbits;
        OFS_PULL_UP:   pu_q     <= wbits;
        OFS_PULL_DN:   pd_q     <= wbits;
        OFS_IN_EN:     ie_q     <= wbits;
        OFS_EV_TYPE:   evtyp_q  <= wbits;
        OFS_EV_BOTH:   evboth_q <= wbits;
        OFS_EV_EN:     even_q   <= wbits;
        OFS_EV_EN_SET: even_q   <= even_q | wbits;
        OFS_EV_EN_CLR: even_q   <= even_q & ~wbits;
        default: ;
      endcase
    end
  end

  gpio_lock_ctrl u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_waddr),
    .wdata  (cfg_wdata),
    .locked (locked),
    .armed  (unlock_armed)
  );

  gpio_pin_resolve #(.NPIN(NPIN)) u_pins (
    .dout (dout_q),
    .pol  (pol_q),
    .oe   (oe_q),
    .otyp (otyp_q),
    .pu   (pu_q),
    .pd   (pd_q),
    .ie   (ie_q),
    .pin  (pin_o),
    .din  (din)
  );

  gpio_event_unit #(.NPIN(NPIN)) u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .mode_edge (evtyp_q),
    .mode_both (evboth_q),
    .ack       (ack_bits),
    .en        (even_q),
    .status    (ev_status),
    .irq       (irq)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_raddr)
      OFS_LOCK_PRI: cfg_rdata[0]      = locked;
      OFS_DATA_IN:  cfg_rdata[NPIN-1:0] = din;
      OFS_POLARITY: cfg_rdata[NPIN-1:0] = pol_q;
      OFS_DOUT:     cfg_rdata[NPIN-1:0] = dout_q;
      OFS_OUT_EN:   cfg_rdata[NPIN-1:0] = oe_q;
      OFS_OUT_TYPE: cfg_rdata[NPIN-1:0] = otyp_q;
      OFS_PULL_UP:  cfg_rdata[NPIN-1:0] = pu_q;
      OFS_PULL_DN:  cfg_rdata[NPIN-1:0] = pd_q;
      OFS_IN_EN:    cfg_rdata[NPIN-1:0] = ie_q;
      OFS_EV_TYPE:  cfg_rdata[NPIN-1:0] = evtyp_q;
      OFS_EV_BOTH:  cfg_rdata[NPIN-1:0] = evboth_q;
      OFS_EV_EN:    cfg_rdata[NPIN-1:0] = even_q;
      OFS_EV_STAT:  cfg_rdata[NPIN-1:0] = ev_status;
      default: ;    // aliases and holes read zero
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [OFS_W-1:0] cfg_waddr,
  input logic [BUS_W-1:0] cfg_wdata,
  input logic             locked,
  input logic             armed,
  input logic [NPIN-1:0]  dout_q,
  input logic [NPIN-1:0]  pol_q,
  input logic [NPIN-1:0]  oe_q,
  input logic [NPIN-1:0]  otyp_q,
  input logic [NPIN-1:0]  ie_q,
  input logic [NPIN-1:0]  pin_o,
  input logic [NPIN-1:0]  din,
  input logic [NPIN-1:0]  ev_status,
  input logic [NPIN-1:0]  even_q,
  input logic             irq
);
  AST_DOUT_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked && cfg_we && (cfg_waddr == OFS_DOUT || cfg_waddr == OFS_DOUT_SET ||
    cfg_waddr == OFS_DOUT_CLR) |=> $stable(dout_q)); // R6

  AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(cfg_we && cfg_waddr == OFS_LOCK_PRI &&
    cfg_wdata == KEY_OPEN && armed)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_waddr == OFS_EV_STAT) |=>
    ((ev_status & $past(ev_status)) == $past(ev_status))); // R11

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (even_q == '0) |-> !irq); // R12

  AST_OD_SINK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_q & otyp_q & ~(dout_q ^ pol_q) & pin_o) == '0)); // R3

  AST_MASKED_READS_POL: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ie_q & (din ^ pol_q)) == '0)); // R4
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_waddr (cfg_waddr),
  .cfg_wdata (cfg_wdata),
  .locked    (locked),
  .armed     (unlock_armed),
  .dout_q    (dout_q),
  .pol_q     (pol_q),
  .oe_q      (oe_q),
  .otyp_q    (otyp_q),
  .ie_q      (ie_q),
  .pin_o     (pin_o),
  .din       (din),
  .ev_status (ev_status),
  .even_q    (even_q),
  .irq       (irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam logic [6:0] A_LK1 = 7'h00, A_DIN = 7'h04, A_POL = 7'h08, A_DO = 7'h0C;
  localparam logic [6:0] A_OE = 7'h10, A_OT = 7'h14, A_PU = 7'h1C, A_PD = 7'h20;
  localparam logic [6:0] A_ETY = 7'h28, A_EBE = 7'h2C, A_EEN = 7'h40, A_EES = 7'h44;
  localparam logic [6:0] A_EEC = 7'h48, A_EST = 7'h4C, A_IE = 7'h58, A_DOS = 7'h68;
  localparam logic [6:0] A_DOC = 7'h6C, A_OES = 7'h70, A_OEC = 7'h74, A_LK2 = 7'h7C;
  localparam logic [31:0] K_ARM = 32'hC0DE1248, K_OPEN = 32'hC0DEFA73;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [6:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] pin_o;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .pin_o(pin_o), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    cfg_raddr = a; #1;
    chk(req, cfg_rdata, exp);
  endtask

  function automatic logic [31:0] exp_pin(input logic [31:0] dout, pol, oe, otyp, pu, pd);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic drv, pull;
      drv = dout[i] ^ pol[i];
      pull = pu[i] && !pd[i];
      if (oe[i] && !otyp[i]) r[i] = drv;
      else if (oe[i] && !drv) r[i] = 1'b0;
      else r[i] = pull;
    end
    return r;
  endfunction

  task automatic t_reset();
    rd_chk("R1 pull-up", A_PU, 32'hFFFFFFFF);
    rd_chk("R1 input enable", A_IE, 32'hFFFFFFFF);
    rd_chk("R1 data-out", A_DO, 32'h0);
    rd_chk("R1 output enable", A_OE, 32'h0);
    rd_chk("R1 polarity", A_POL, 32'h0);
    rd_chk("R1 event enable", A_EEN, 32'h0);
    rd_chk("R1 lock", A_LK1, 32'h0);
    rd_chk("R1 data-in", A_DIN, 32'hFFFFFFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_push_pull();
    wr(A_OE, 32'hFFFFFFFF);
    wr(A_PU, 32'hFFFF0000);
    wr(A_PD, 32'h0000FFFF);
    wr(A_DO, 32'h3C5A96E1);
    rd_chk("R2 data-in follows data-out", A_DIN, 32'h3C5A96E1);
    wr(A_POL, 32'h0F0F0F0F);
    #1 chk("R2 pin is inverted drive", pin_o, 32'h335599EE);
    rd_chk("R2 data-in re-inverted", A_DIN, 32'h3C5A96E1);
    wr(A_POL, 32'h0);
  endtask

  task automatic t_open_drain();
    logic [31:0] e;
    wr(A_OT, 32'hA5A5A5A5);
    wr(A_OE, 32'hFF00FF00);
    wr(A_DO, 32'hF0F0F0F0);
    wr(A_PU, 32'hCCCCCCCC);
    wr(A_PD, 32'h33333333);
    e = exp_pin(32'hF0F0F0F0, 32'h0, 32'hFF00FF00, 32'hA5A5A5A5, 32'hCCCCCCCC, 32'h33333333);
    #1 chk("R3 open-drain pins", pin_o, e);
    rd_chk("R3 open-drain data-in", A_DIN, e);
    wr(A_PD, 32'hFFFFFFFF);   // pull-up and pull-down both set: pull is 0
    e = exp_pin(32'hF0F0F0F0, 32'h0, 32'hFF00FF00, 32'hA5A5A5A5, 32'hCCCCCCCC, 32'hFFFFFFFF);
    #1 chk("R3 conflicting pulls", pin_o, e);
    wr(A_OT, 32'h0);
    wr(A_PD, 32'h0);
    wr(A_PU, 32'hFFFFFFFF);
  endtask

  task automatic t_mask();
    wr(A_OE, 32'hFFFFFFFF);
    wr(A_DO, 32'h6789ABCD);
    wr(A_POL, 32'hFF00FF00);
    wr(A_IE, 32'h0000FFFF);
    rd_chk("R4 masked bits read polarity", A_DIN, 32'hFF00ABCD);
    wr(A_IE, 32'hFFFFFFFF);
    wr(A_POL, 32'h0);
  endtask

  task automatic t_alias();
    wr(A_OE, 32'h0);
    wr(A_OES, 32'h0000F00F);
    rd_chk("R5 oe set", A_OE, 32'h0000F00F);
    wr(A_OEC, 32'h0000000F);
    rd_chk("R5 oe clear", A_OE, 32'h0000F000);
    rd_chk("R5 alias reads zero", A_OES, 32'h0);
    wr(A_DO, 32'h0);
    wr(A_DOS, 32'h81);
    wr(A_DOC, 32'h01);
    rd_chk("R5 data-out set/clear", A_DO, 32'h80);
    wr(A_EEN, 32'h0);
    wr(A_EES, 32'h30);
    wr(A_EEC, 32'h10);
    rd_chk("R5 event enable set/clear", A_EEN, 32'h20);
    wr(A_EEN, 32'h0);
  endtask

  task automatic t_lock();
    wr(A_DO, 32'h11);
    wr(A_LK1, 32'h0);
    rd_chk("R6 lock reads 1", A_LK1, 32'h1);
    wr(A_DO, 32'h22);
    wr(A_DOS, 32'hF00);
    wr(A_DOC, 32'h01);
    rd_chk("R6 data-out frozen", A_DO, 32'h11);
    wr(A_POL, 32'h5);
    rd_chk("R6 other regs writable", A_POL, 32'h5);
    wr(A_LK2, K_ARM);
    wr(A_POL, 32'h0);
    wr(A_LK1, K_OPEN);
    rd_chk("R7 broken sequence stays locked", A_LK1, 32'h1);
    wr(A_LK2, K_ARM);
    wr(A_LK1, 32'h12345678);
    rd_chk("R7 wrong key stays locked", A_LK1, 32'h1);
    wr(A_LK2, K_ARM);
    wr(A_LK1, K_OPEN);
    rd_chk("R7 unlocked", A_LK1, 32'h0);
    wr(A_DO, 32'h22);
    rd_chk("R7 data-out writable again", A_DO, 32'h22);
    wr(A_LK2, 32'h0);
    rd_chk("R6 lock via secondary", A_LK1, 32'h1);
    wr(A_LK2, K_ARM);
    wr(A_LK1, K_OPEN);
    rd_chk("R7 unlock again", A_LK1, 32'h0);
  endtask

  task automatic t_level();
    wr(A_OE, 32'hFFFFFFFF);
    wr(A_ETY, 32'h0);
    wr(A_DO, 32'hF0);
    tick();
    wr(A_EST, 32'hFFFFFFFF);
    rd_chk("R8 level sets status", A_EST, 32'hF0);
    wr(A_DO, 32'h0);
    tick();
    rd_chk("R8 status sticky after fall", A_EST, 32'hF0);
    wr(A_EST, 32'h30);
    rd_chk("R11 partial clear", A_EST, 32'hC0);
    wr(A_EST, 32'hC0);
    rd_chk("R11 full clear", A_EST, 32'h0);
    wr(A_DO, 32'h1);
    tick();
    wr(A_EST, 32'h1);
    rd_chk("R11 event beats clear", A_EST, 32'h1);
    wr(A_DO, 32'h0);
    tick();
    wr(A_EST, 32'hFFFFFFFF);
  endtask

  task automatic t_edges();
    wr(A_ETY, 32'hFFFFFFFF);
    wr(A_EBE, 32'hFFFFFFFF);
    wr(A_DO, 32'h0FF0);
    tick();
    wr(A_EST, 32'hFFFFFFFF);
    rd_chk("R10 cleared", A_EST, 32'h0);
    wr(A_DO, 32'h00FF);
    rd_chk("R13 no status before next edge", A_EST, 32'h0);
    tick();
    rd_chk("R10 both edges", A_EST, 32'hF0F);
    wr(A_EBE, 32'h0);
    wr(A_DO, 32'hFF00);
    tick();
    wr(A_EST, 32'hFFFFFFFF);
    rd_chk("R9 cleared", A_EST, 32'h0);
    wr(A_DO, 32'h0FF0);
    tick();
    rd_chk("R9 rising only", A_EST, 32'hF0);
    tick();
    wr(A_EST, 32'hF0);
    rd_chk("R13 one event per change", A_EST, 32'h0);
  endtask

  task automatic t_irq();
    wr(A_ETY, 32'h0);
    wr(A_DO, 32'h0);
    wr(A_EEN, 32'h0);
    tick();
    wr(A_EST, 32'hFFFFFFFF);
    #1 chk("R12 irq idle", {31'b0, irq}, 32'h0);
    wr(A_DOS, 32'h100);
    tick();
    rd_chk("R8 status from set alias", A_EST, 32'h100);
    chk("R12 masked irq", {31'b0, irq}, 32'h0);
    wr(A_EES, 32'h100);
    #1 chk("R12 irq on enable", {31'b0, irq}, 32'h1);
    wr(A_EEC, 32'h100);
    #1 chk("R12 irq off on disable", {31'b0, irq}, 32'h0);
    wr(A_EES, 32'h100);
    wr(A_DOC, 32'h100);
    tick();
    #1 chk("R12 irq held by sticky status", {31'b0, irq}, 32'h1);
    wr(A_EST, 32'h100);
    #1 chk("R12 irq drops on clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pull();
    t_open_drain();
    t_mask();
    t_alias();
    t_lock();
    t_level();
    t_edges();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule